// File: doc/BRIEF.md
# Special Register Access Stretcher

This block sits on the local register bus in front of a sparse group of specially handled peripheral registers. For every accepted request it checks the addressed byte, and the next byte when the request is 16 bits wide, against a fixed set of special addresses. From the access width, the byte alignment and the number of special bytes touched, it works out how many bus cycles the access lasts. It then drives a one-cycle `bus_ready` pulse in the final cycle of that count.

The block also stalls the main CPU. When the coprocessor or the debug port accesses a special register, `cpu_halt` holds the main CPU for the whole access. Timing is the same in every operating mode of the chip.

A master presents a request by holding `req_valid` with its address, width and identity. It keeps them unchanged until it sees `bus_ready`. It may present its next request in that same ready cycle. An access that touches no special byte completes in the first cycle after acceptance.

Top module: `slow_reg_timer`

## Requirements
- R1: A synchronous active-high `rst` forces `bus_ready` and `cpu_halt` low in the cycle after the reset edge, aborts any access in progress, and leaves the block ready to accept a request.
- R2: An accepted request that touches no special byte raises `bus_ready` in the first cycle after the accepting edge, for one cycle, with `cpu_halt` low.
- R3: A byte request (`req_word` = 0) to a special address raises `bus_ready` in the second cycle after the accepting edge.
- R4: A word request at an even address that touches special bytes raises `bus_ready` in the second cycle after the accepting edge.
- R5: A word request at an odd address whose two bytes are both special raises `bus_ready` in the fourth cycle after the accepting edge.
- R6: A word request at an odd address with exactly one special byte raises `bus_ready` in the third cycle after the accepting edge.
- R7: The special addresses are 0x0000 to 0x000F, 0x0012, 0x0013, 0x001C, 0x001D, 0x0032 and 0x0033, with all upper address bits zero. Every other address, for example 0x0010, 0x0011, 0x001E, 0x0034 or 0x1000, is ordinary.
- R8: `req_master` encodes 0 as the main CPU, 1 as the coprocessor and 2 as the debug port. A request from a nonzero master that touches a special byte holds `cpu_halt` high from the first cycle after acceptance through the ready cycle. `cpu_halt` stays low for master 0 and for accesses that touch no special byte.
- R9: During a stretched access of N cycles, `bus_ready` is low in cycles 1 to N-1 and high in cycle N. If no new request is accepted, both outputs are low in cycle N+1.
- R10: A request presented while a stretched access is still before its ready cycle is ignored and does not change the running access's timing or halt.
- R11: A request presented during a ready cycle is accepted at the edge that ends that cycle, so accesses can run back to back.
- R12: `req_word` = 1 selects a 16-bit access that covers `req_addr` and `req_addr + 1`. `req_word` = 0 selects a single byte at `req_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W (16) | Local byte address |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_master | input | 2 | Requesting master: 0 CPU, 1 coprocessor, 2 debug port |
| bus_ready | output | 1 | Access completes in this cycle (registered) |
| cpu_halt | output | 1 | Main CPU stall (registered) |

## Verification
The bench counts every result from the accepting edge. Cycle k after that edge runs until the k-th following rising edge, and `bus_ready` is due in cycle 1, 2, 3 or 4 depending on the access class. The bench drives and samples only on falling edges and checks both outputs in every cycle from 1 to N, then once more in cycle N+1 to confirm the block has gone idle. Three further cases are timed by the same count:
- requests placed before the ready cycle (R10);
- a request placed in the ready cycle (R11);
- a reset applied in the middle of an access.

// File: rtl/slow_reg_pkg.sv
package slow_reg_pkg;

  typedef enum logic [1:0] {
    MST_CPU   = 2'd0,
    MST_COPRO = 2'd1,
    MST_DEBUG = 2'd2,
    MST_SPARE = 2'd3
  } master_e;

  // contiguous special window starting at address zero
  localparam int LOW_SPAN = 16;

  // isolated special pairs, each starting at an even address
  localparam int NUM_PAIRS = 3;
  localparam int PAIR_BASE [NUM_PAIRS] = '{'h12, 'h1C, 'h32};

  // access length classes in bus cycles
  localparam int CYC_PLAIN      = 1;
  localparam int CYC_SINGLE     = 2;
  localparam int CYC_SPLIT_ONE  = 3;
  localparam int CYC_SPLIT_BOTH = 4;

endpackage

// File: rtl/slow_reg_decode.sv
module slow_reg_decode #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_special
);
  import slow_reg_pkg::*;

  logic               in_low;
  logic [NUM_PAIRS-1:0] pair_hit;
  logic [ADDR_W-1:0]  even_addr;

  assign even_addr = {addr[ADDR_W-1:1], 1'b0};
  assign in_low    = (addr < ADDR_W'(LOW_SPAN));

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign pair_hit[p] = (even_addr == ADDR_W'(PAIR_BASE[p]));
  end

  assign is_special = in_low | (|pair_hit);

endmodule

// File: rtl/slow_reg_seq.sv
module slow_reg_seq #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [CNT_W-1:0] cost,
  input  logic             stall_req,
  output logic             active,
  output logic             last,
  output logic             bus_ready,
  output logic             cpu_halt
);
  logic [CNT_W-1:0] remain;

  assign last = (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      remain    <= '0;
      bus_ready <= 1'b0;
      cpu_halt  <= 1'b0;
    end else if (take) begin
      active    <= 1'b1;
      remain    <= cost - CNT_W'(1);
      bus_ready <= (cost == CNT_W'(1));
      cpu_halt  <= stall_req;
    end else if (active) begin
      if (!last) begin
        remain    <= remain - CNT_W'(1);
        bus_ready <= (remain == CNT_W'(1));
      end else begin
        active    <= 1'b0;
        bus_ready <= 1'b0;
        cpu_halt  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/slow_reg_timer.sv
module slow_reg_timer #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic [1:0]        req_master,
  output logic              bus_ready,
  output logic              cpu_halt
);
  import slow_reg_pkg::*;

  localparam int LANES = 2;

  logic [LANES-1:0] lane_sp;
  logic             lo_sp, hi_sp, any_sp, misaligned, secondary;
  logic [CNT_W-1:0] cost;
  logic             active, last, take;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    slow_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr       (req_addr + ADDR_W'(l)),
      .is_special (lane_sp[l])
    );
  end

  assign lo_sp      = lane_sp[0];
  assign hi_sp      = req_word & lane_sp[1];
  assign any_sp     = lo_sp | hi_sp;
  assign misaligned = req_word & req_addr[0];
  assign secondary  = (req_master != MST_CPU);

  always_comb begin
    if (!any_sp)
      cost = CNT_W'(CYC_PLAIN);
    else if (!misaligned)
      cost = CNT_W'(CYC_SINGLE);
    else if (lo_sp && hi_sp)
      cost = CNT_W'(CYC_SPLIT_BOTH);
    else
      cost = CNT_W'(CYC_SPLIT_ONE);
  end

  assign take = req_valid & (~active | last);

  slow_reg_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .cost      (cost),
    .stall_req (secondary & any_sp),
    .active    (active),
    .last      (last),
    .bus_ready (bus_ready),
    .cpu_halt  (cpu_halt)
  );

endmodule

// File: rtl/slow_reg_checker.sv
module slow_reg_checker (
  input logic       clk,
  input logic       rst,
  input logic       take,
  input logic       active,
  input logic [1:0] req_master,
  input logic       bus_ready,
  input logic       cpu_halt
);
  logic [2:0] span;
  logic [1:0] seen_master;

  always_ff @(posedge clk) begin
    if (rst) begin
      span        <= '0;
      seen_master <= '0;
    end else if (take) begin
      span        <= 3'd1;
      seen_master <= req_master;
    end else if (active && span != 3'd7) begin
      span <= span + 3'd1;
    end
  end

  // R1: outputs quiet right after a reset edge
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!bus_ready && !cpu_halt));

  // R8: only a secondary master can stall the CPU
  a_r8_halt_secondary: assert property (@(posedge clk) disable iff (rst)
    cpu_halt |-> (seen_master != 2'd0));

  // R9: completion never later than four cycles after acceptance
  a_r9_ready_window: assert property (@(posedge clk) disable iff (rst)
    bus_ready |-> (span >= 3'd1 && span <= 3'd4));

  // R9: halt drops after a ready cycle unless another access starts
  a_r9_halt_release: assert property (@(posedge clk) disable iff (rst)
    (bus_ready && !take) |=> !cpu_halt);

  // R8: halt starts only in the first cycle of an access
  a_r8_halt_start: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_halt) |-> (span == 3'd1));

endmodule

bind slow_reg_timer slow_reg_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .take       (take),
  .active     (active),
  .req_master (req_master),
  .bus_ready  (bus_ready),
  .cpu_halt   (cpu_halt)
);

// File: tb/slow_reg_timer_test.sv
module slow_reg_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_word = 1'b0;
  logic [1:0]  req_master = '0;
  logic        bus_ready, cpu_halt;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slow_reg_timer uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_word(req_word), .req_master(req_master),
    .bus_ready(bus_ready), .cpu_halt(cpu_halt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic present(input logic [15:0] a, input logic w, input logic [1:0] m);
    req_valid = 1'b1; req_addr = a; req_word = w; req_master = m;
  endtask

  // one access of n cycles; checks every cycle and the idle cycle after it
  task automatic access(input string tag, input logic [15:0] a, input logic w,
                        input logic [1:0] m, input int n, input logic halt);
    @(negedge clk); present(a, w, m);
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    for (int k = 1; k <= n; k++) begin
      check({tag, " ready"}, bus_ready, (k == n));
      check({tag, " halt"}, cpu_halt, halt);
      @(negedge clk);
    end
    check({tag, " idle ready"}, bus_ready, 1'b0);
    check({tag, " idle halt"}, cpu_halt, 1'b0);
  endtask

  task automatic t_reset_state;
    check("R1 ready after reset", bus_ready, 1'b0);
    check("R1 halt after reset", cpu_halt, 1'b0);
  endtask

  task automatic t_plain;
    access("R2 byte 0x0010", 16'h0010, 1'b0, 2'd0, 1, 1'b0);
    access("R2 R8 debug word 0x0040", 16'h0040, 1'b1, 2'd2, 1, 1'b0);
    access("R2 R7 byte 0x1000", 16'h1000, 1'b0, 2'd1, 1, 1'b0);
  endtask

  task automatic t_byte;
    access("R3 cpu byte 0x000A", 16'h000A, 1'b0, 2'd0, 2, 1'b0);
    access("R3 R8 copro byte 0x001D", 16'h001D, 1'b0, 2'd1, 2, 1'b1);
  endtask

  task automatic t_aligned;
    access("R4 R12 word 0x0000", 16'h0000, 1'b1, 2'd0, 2, 1'b0);
    access("R4 R8 debug word 0x0032", 16'h0032, 1'b1, 2'd2, 2, 1'b1);
  endtask

  task automatic t_split_both;
    access("R5 word 0x0001", 16'h0001, 1'b1, 2'd0, 4, 1'b0);
    access("R5 R8 copro word 0x000D", 16'h000D, 1'b1, 2'd1, 4, 1'b1);
  endtask

  task automatic t_split_one;
    access("R6 word 0x000F", 16'h000F, 1'b1, 2'd0, 3, 1'b0);
    access("R6 R12 debug word 0x0011", 16'h0011, 1'b1, 2'd2, 3, 1'b1);
    access("R6 word 0x0033", 16'h0033, 1'b1, 2'd0, 3, 1'b0);
  endtask

  task automatic t_map;
    access("R7 byte 0x0012", 16'h0012, 1'b0, 2'd0, 2, 1'b0);
    access("R7 byte 0x001C", 16'h001C, 1'b0, 2'd0, 2, 1'b0);
    access("R7 byte 0x001E", 16'h001E, 1'b0, 2'd0, 1, 1'b0);
    access("R7 byte 0x0034", 16'h0034, 1'b0, 2'd0, 1, 1'b0);
    access("R7 byte 0x0011", 16'h0011, 1'b0, 2'd0, 1, 1'b0);
    access("R7 R12 word 0x0010", 16'h0010, 1'b1, 2'd1, 1, 1'b0);
  endtask

  task automatic t_ignore;
    @(negedge clk); present(16'h0001, 1'b1, 2'd1);
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    check("R10 c1 ready", bus_ready, 1'b0);
    check("R10 c1 halt", cpu_halt, 1'b1);
    @(negedge clk); present(16'h0010, 1'b0, 2'd0);
    check("R10 c2 ready", bus_ready, 1'b0);
    @(negedge clk);
    check("R10 c3 ready", bus_ready, 1'b0);
    check("R10 c3 halt", cpu_halt, 1'b1);
    @(negedge clk); req_valid = 1'b0;
    check("R10 c4 ready", bus_ready, 1'b1);
    check("R10 c4 halt", cpu_halt, 1'b1);
    @(negedge clk);
    check("R10 c5 ready", bus_ready, 1'b0);
    check("R10 c5 halt", cpu_halt, 1'b0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk); present(16'h0005, 1'b0, 2'd2);
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    check("R11 c1 ready", bus_ready, 1'b0);
    @(negedge clk); present(16'h0040, 1'b0, 2'd0);
    check("R11 c2 ready", bus_ready, 1'b1);
    check("R11 c2 halt", cpu_halt, 1'b1);
    @(negedge clk); req_valid = 1'b0;
    check("R11 next ready", bus_ready, 1'b1);
    check("R11 next halt", cpu_halt, 1'b0);
    @(negedge clk);
    check("R11 idle ready", bus_ready, 1'b0);
  endtask

  task automatic t_reset_mid;
    @(negedge clk); present(16'h0003, 1'b1, 2'd1);
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 mid ready", bus_ready, 1'b0);
    check("R1 mid halt", cpu_halt, 1'b0);
    access("R1 after reset", 16'h0020, 1'b0, 2'd0, 1, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset_state();
    t_plain();
    t_byte();
    t_aligned();
    t_split_both();
    t_split_one();
    t_map();
    t_ignore();
    t_back_to_back();
    t_reset_mid();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule